// File: doc/BRIEF.md
# Dynamic bus sizing sequencer

The sequencer sits between a 32-bit processor-side request and an external bus whose port may be 8, 16 or 32 bits wide. A request names a byte address, an operand length of one to four bytes, a direction and a cachable flag. The block runs as many bus cycles as it needs to move the whole operand. Each cycle drives a two-bit size code for the bytes still outstanding and the current address. The port answers with an acknowledge code that gives its width. The sequencer uses that width to work out how many bytes the cycle moved, then advances the address and the remaining count.

On writes, each operand byte is copied onto every data lane that a port of any width could sample for that address. A narrow port therefore latches the right byte without knowing its own position. On reads, the bytes are taken from the lanes that the reported port width implies and packed into an assembly register. A one-cycle done pulse presents the result. For reads, the block also flags the lanes that must carry valid data. For a cachable read this is the full port width; for a non-cachable read it is only the requested bytes.

Top module: `dbs_sequencer`

## Requirements
- R1: While a cycle is active, `bus_siz_o` encodes the bytes still to move: 1 as 01, 2 as 10, 3 as 11, 4 as 00. The first cycle carries the request length and the request address.
- R2: `bus_ack_i` encodes 00 as not finished, 01 as an 8-bit port, 10 as a 16-bit port and 11 as a 32-bit port. While it reads 00, the active cycle and its address and size code stay unchanged.
- R3: Let o be the low two address bits. An acknowledged cycle moves the smaller of the remaining count and the room to the port boundary: 1 byte for an 8-bit port, 2 minus o[0] for a 16-bit port, 4 minus o for a 32-bit port. The address rises and the remaining count falls by that number. The last cycle ends when the count reaches zero.
- R4: Read bytes are packed left-justified into `rdata_o`, with operand byte k in bits [31-8k:24-8k]; bytes beyond the length read zero. `done_o` is high for exactly one cycle, the cycle after the final acknowledge, and `rdata_o` is valid then.
- R5: On reads, the sequencer takes the cycle's first byte from a fixed lane that depends on the port width. For a 32-bit port this is lane o. For a 16-bit port it is lane o[0]. For an 8-bit port it is lane 0. Further bytes come from the lanes that follow. Lane L is data bits [31-8L:24-8L].
- R6: On writes, lane L (L = o to 3) carries the operand byte for address o+L-o within the 32-bit group. Lanes 0 and 1 otherwise carry the bytes for the 16-bit halfword. Every other lane, and lane 0 always, carries the cycle's first byte. As a result, a memory behind a port of any width ends up holding the operand.
- R7: `bus_lane_need_o` bit i covers data bits [8i+7:8i]. For a non-cachable read, it flags exactly the lanes that hold requested bytes. It is all zero for writes and when no cycle is active.
- R8: For a cachable read, `bus_lane_need_o` flags every lane the port covers: 1000 for an 8-bit port, 1100 for a 16-bit port, and 1111 for a 32-bit port or while the acknowledge reads 00.
- R9: A request is accepted only while `req_ready_o` is high (idle). Request inputs presented during a transfer have no effect on it.
- R10: Asserting `rst_ni` low returns the block at once to idle: no cycle is active, `req_ready_o` is high and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Idle, request will be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_cache_i | input | 1 | Read is cachable |
| req_addr_i | input | ADDR_W | Byte address of the operand |
| req_len_i | input | 3 | Operand length, 1 to 4 |
| req_wdata_i | input | 32 | Write operand, left-justified |
| done_o | output | 1 | Transfer complete pulse |
| rdata_o | output | 32 | Assembled read operand, left-justified |
| bus_cyc_o | output | 1 | Bus cycle active |
| bus_rd_o | output | 1 | Cycle direction, 1 = read |
| bus_addr_o | output | ADDR_W | Cycle address |
| bus_siz_o | output | 2 | Size code for remaining bytes |
| bus_lane_need_o | output | 4 | Lanes that must be valid on reads |
| bus_data_o | output | 32 | Routed write lanes |
| bus_data_i | input | 32 | Read lanes from the port |
| bus_ack_i | input | 2 | Cycle acknowledge and port width |

## Verification
Wrong internal state shows at the ports within one cycle. A bad remaining count appears at once as a wrong size code on the next cycle, or as a missing or extra cycle. A bad address or operand index shows as the wrong bytes landing in the bench's byte memory, or in the read result, when done pulses. Bad lane flags are visible in the acknowledging cycle itself. A stuck busy flag shows as a missing done pulse. This is why each transfer is compared on its cycle count, size-code sequence, first-cycle lane flags and final data.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int DATA_W = LANES * BYTE_W;
  localparam int HALF   = LANES / 2;
  localparam int CNT_W  = $clog2(LANES) + 1;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    ACK_WAIT = 2'b00,
    ACK_P8   = 2'b01,
    ACK_P16  = 2'b10,
    ACK_P32  = 2'b11
  } ack_e;

  // lane 0 is the most significant byte
  function automatic logic [BYTE_W-1:0] lane_get(input logic [DATA_W-1:0] d, input int l);
    return d[BYTE_W*(LANES-1-l) +: BYTE_W];
  endfunction
endpackage

// File: rtl/dbs_step.sv
module dbs_step
  import dbs_pkg::*;
(
  input  logic [1:0]       off_i,
  input  cnt_t             rem_i,
  input  logic [1:0]       ack_i,
  input  logic             rd_i,
  input  logic             cache_i,
  output cnt_t             nbytes_o,
  output logic [1:0]       base_o,
  output logic [LANES-1:0] need_o
);
  int width, base, room, n;
  logic in_req, in_port;

  always_comb begin
    case (ack_e'(ack_i))
      ACK_P8:  begin width = 1;    base = 0;               end
      ACK_P16: begin width = HALF; base = int'(off_i[0]);  end
      default: begin width = LANES; base = int'(off_i);    end
    endcase
    room     = width - base;
    n        = (int'(rem_i) < room) ? int'(rem_i) : room;
    nbytes_o = cnt_t'(n);
    base_o   = 2'(base);
    in_req   = 1'b0;
    in_port  = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      in_req  = (l >= base) && (l < base + n);
      in_port = (l < width);
      need_o[LANES-1-l] = rd_i && (cache_i ? in_port : in_req);
    end
  end
endmodule

// File: rtl/dbs_wr_route.sv
module dbs_wr_route
  import dbs_pkg::*;
(
  input  logic [DATA_W-1:0] op_i,
  input  cnt_t              idx_i,
  input  logic [1:0]        off_i,
  input  cnt_t              rem_i,
  output logic [DATA_W-1:0] lanes_o
);
  int o32, o16, sel;

  always_comb begin
    lanes_o = '0;
    o32 = 0;
    o16 = 0;
    sel = 0;
    for (int l = 0; l < LANES; l++) begin
      o32 = l - int'(off_i);
      o16 = l - int'(off_i[0]);
      if (o32 >= 0 && o32 < int'(rem_i))
        sel = int'(idx_i) + o32;
      else if (l < HALF && o16 >= 0 && o16 < int'(rem_i))
        sel = int'(idx_i) + o16;
      else
        sel = int'(idx_i);   // duplicate first byte for narrow ports
      lanes_o[BYTE_W*(LANES-1-l) +: BYTE_W] = lane_get(op_i, sel & (LANES-1));
    end
  end
endmodule

// File: rtl/dbs_assembler.sv
module dbs_assembler
  import dbs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] lanes_i,
  input  logic [1:0]        base_i,
  input  cnt_t              idx_i,
  input  cnt_t              n_i,
  output logic [DATA_W-1:0] asm_o
);
  logic [DATA_W-1:0] asm_q, asm_d;
  int dst, src;

  always_comb begin
    asm_d = asm_q;
    dst = 0;
    src = 0;
    if (clear_i) begin
      asm_d = '0;
    end else if (cap_i) begin
      for (int j = 0; j < LANES; j++) begin
        dst = int'(idx_i) + j;
        src = int'(base_i) + j;
        if (j < int'(n_i) && dst < LANES && src < LANES)
          asm_d[BYTE_W*(LANES-1-dst) +: BYTE_W] = lane_get(lanes_i, src);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) asm_q <= '0;
    else         asm_q <= asm_d;
  end

  assign asm_o = asm_q;
endmodule

// File: rtl/dbs_sequencer.sv
module dbs_sequencer
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic              req_cache_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [2:0]        req_len_i,
  input  logic [31:0]       req_wdata_i,
  output logic              done_o,
  output logic [31:0]       rdata_o,
  output logic              bus_cyc_o,
  output logic              bus_rd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [1:0]        bus_siz_o,
  output logic [3:0]        bus_lane_need_o,
  output logic [31:0]       bus_data_o,
  input  logic [31:0]       bus_data_i,
  input  logic [1:0]        bus_ack_i
);
  logic              busy_q, wr_q, cache_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  cnt_t              rem_q, idx_q;
  logic [DATA_W-1:0] wdata_q;

  cnt_t              nbytes;
  logic [1:0]        base;
  logic [LANES-1:0]  need;
  logic              accept, ack_hit, last;

  assign accept  = req_valid_i && !busy_q;
  assign ack_hit = busy_q && (bus_ack_i != ACK_WAIT);
  assign last    = ack_hit && (nbytes == rem_q);

  dbs_step u_step (
    .off_i    (addr_q[1:0]),
    .rem_i    (rem_q),
    .ack_i    (bus_ack_i),
    .rd_i     (busy_q && !wr_q),
    .cache_i  (cache_q),
    .nbytes_o (nbytes),
    .base_o   (base),
    .need_o   (need)
  );

  dbs_wr_route u_route (
    .op_i    (wdata_q),
    .idx_i   (idx_q),
    .off_i   (addr_q[1:0]),
    .rem_i   (rem_q),
    .lanes_o (bus_data_o)
  );

  dbs_assembler u_asm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .cap_i   (ack_hit && !wr_q),
    .lanes_i (bus_data_i),
    .base_i  (base),
    .idx_i   (idx_q),
    .n_i     (nbytes),
    .asm_o   (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      wr_q    <= 1'b0;
      cache_q <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      rem_q   <= '0;
      idx_q   <= '0;
      wdata_q <= '0;
    end else begin
      done_q <= last;
      if (accept) begin
        busy_q  <= 1'b1;
        wr_q    <= req_write_i;
        cache_q <= req_cache_i;
        addr_q  <= req_addr_i;
        rem_q   <= cnt_t'(req_len_i);
        idx_q   <= '0;
        wdata_q <= req_wdata_i;
      end else if (ack_hit) begin
        addr_q <= addr_q + ADDR_W'(nbytes);
        rem_q  <= rem_q - nbytes;
        idx_q  <= idx_q + nbytes;
        if (last) busy_q <= 1'b0;
      end
    end
  end

  assign req_ready_o     = !busy_q;
  assign done_o          = done_q;
  assign bus_cyc_o       = busy_q;
  assign bus_rd_o        = !wr_q;
  assign bus_addr_o      = addr_q;
  assign bus_siz_o       = rem_q[1:0];
  assign bus_lane_need_o = busy_q ? need : '0;
endmodule

// File: rtl/dbs_sequencer_chk.sv
module dbs_sequencer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [2:0]        req_len_i,
  input logic              done_o,
  input logic              bus_cyc_o,
  input logic              bus_rd_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [1:0]        bus_siz_o,
  input logic [3:0]        bus_lane_need_o,
  input logic [1:0]        bus_ack_i
);
  assert_hold_on_wait_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cyc_o && bus_ack_i == 2'b00) |=>
      (bus_cyc_o && $stable(bus_addr_o) && $stable(bus_siz_o)));

  assert_addr_advance_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cyc_o && bus_ack_i != 2'b00) |=>
      (!bus_cyc_o || ((bus_addr_o != $past(bus_addr_o)) &&
                      ((bus_addr_o - $past(bus_addr_o)) < ADDR_W'(4)))));

  assert_word_boundary_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cyc_o && bus_ack_i == 2'b11) |=> (!bus_cyc_o || bus_addr_o[1:0] == 2'b00));

  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_no_need_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_cyc_o && bus_rd_o) |-> (bus_lane_need_o == 4'b0000));

  assert_narrow_need_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cyc_o && bus_rd_o && bus_ack_i == 2'b01) |-> (bus_lane_need_o == 4'b1000));

  assert_ready_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !bus_cyc_o);

  assert_len_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |-> (req_len_i inside {[3'd1:3'd4]}));
endmodule

bind dbs_sequencer dbs_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .req_len_i       (req_len_i),
  .done_o          (done_o),
  .bus_cyc_o       (bus_cyc_o),
  .bus_rd_o        (bus_rd_o),
  .bus_addr_o      (bus_addr_o),
  .bus_siz_o       (bus_siz_o),
  .bus_lane_need_o (bus_lane_need_o),
  .bus_ack_i       (bus_ack_i)
);

// File: tb/dbs_sequencer_tb_top.sv
`timescale 1ns/1ps
module dbs_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_cache = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [2:0]  req_len = 3'd1;
  logic        req_ready, done, bus_cyc, bus_rd;
  logic [31:0] rdata, bus_addr, bus_dout;
  logic [31:0] bus_din = '0;
  logic [1:0]  bus_siz;
  logic [1:0]  bus_ack = 2'b00;
  logic [3:0]  lane_need;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [16];

  always #10 clk = ~clk;

  dbs_sequencer #(.ADDR_W(32)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_cache_i(req_cache),
    .req_addr_i(req_addr), .req_len_i(req_len), .req_wdata_i(req_wdata),
    .done_o(done), .rdata_o(rdata),
    .bus_cyc_o(bus_cyc), .bus_rd_o(bus_rd), .bus_addr_o(bus_addr),
    .bus_siz_o(bus_siz), .bus_lane_need_o(lane_need),
    .bus_data_o(bus_dout), .bus_data_i(bus_din), .bus_ack_i(bus_ack)
  );

  typedef struct packed {
    logic [7:0]  addr;
    logic [2:0]  len;
    logic [1:0]  ack;
    logic        wr;
    logic        cache;
    logic [1:0]  waits;
    logic [31:0] wdata;
    logic [2:0]  ncyc;
    logic [7:0]  siz;
    logic [3:0]  need;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{8'h0, 3'd4, 2'b11, 1'b0, 1'b0, 2'd0, 32'h0,        3'd1, 8'b00_000000, 4'b1111},
    '{8'h1, 3'd4, 2'b11, 1'b0, 1'b0, 2'd0, 32'h0,        3'd2, 8'b00_01_0000, 4'b0111},
    '{8'h1, 3'd4, 2'b11, 1'b0, 1'b1, 2'd0, 32'h0,        3'd2, 8'b00_01_0000, 4'b1111},
    '{8'h0, 3'd4, 2'b01, 1'b0, 1'b0, 2'd0, 32'h0,        3'd4, 8'b00_11_10_01, 4'b1000},
    '{8'h1, 3'd2, 2'b10, 1'b0, 1'b0, 2'd0, 32'h0,        3'd2, 8'b10_01_0000, 4'b0100},
    '{8'h1, 3'd2, 2'b10, 1'b0, 1'b1, 2'd0, 32'h0,        3'd2, 8'b10_01_0000, 4'b1100},
    '{8'h3, 3'd3, 2'b10, 1'b1, 1'b0, 2'd0, 32'hA1B2C300, 3'd2, 8'b11_10_0000, 4'b0000},
    '{8'h2, 3'd3, 2'b11, 1'b0, 1'b0, 2'd0, 32'h0,        3'd2, 8'b11_01_0000, 4'b0011},
    '{8'h5, 3'd4, 2'b11, 1'b1, 1'b0, 2'd0, 32'hDEADBEEF, 3'd2, 8'b00_01_0000, 4'b0000},
    '{8'h7, 3'd1, 2'b01, 1'b1, 1'b0, 2'd0, 32'h5A000000, 3'd1, 8'b01_000000, 4'b0000},
    '{8'h6, 3'd4, 2'b10, 1'b0, 1'b1, 2'd2, 32'h0,        3'd2, 8'b00_10_0000, 4'b1100},
    '{8'h0, 3'd3, 2'b11, 1'b0, 1'b0, 2'd0, 32'h0,        3'd1, 8'b11_000000, 4'b1110},
    '{8'h0, 3'd3, 2'b11, 1'b0, 1'b1, 2'd0, 32'h0,        3'd1, 8'b11_000000, 4'b1111},
    '{8'h2, 3'd2, 2'b10, 1'b1, 1'b0, 2'd0, 32'hCAFE0000, 3'd1, 8'b10_000000, 4'b0000},
    '{8'h3, 3'd4, 2'b01, 1'b1, 1'b0, 2'd1, 32'h12345678, 3'd4, 8'b00_11_10_01, 4'b0000}
  };

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic mem_init();
    for (int i = 0; i < 16; i++) mem[i] = 8'h10 + 8'(i);
  endtask

  // port model: drive read lanes for the port width
  task automatic drive_read(input logic [1:0] w);
    int a;
    a = int'(bus_addr[3:0]);
    bus_din = 32'hEEEEEEEE;
    case (w)
      2'b11: for (int l = 0; l < 4; l++) bus_din[31-8*l -: 8] = mem[((a & 12) + l) & 15];
      2'b10: for (int l = 0; l < 2; l++) bus_din[31-8*l -: 8] = mem[((a & 14) + l) & 15];
      default: bus_din[31:24] = mem[a];
    endcase
  endtask

  // port model: latch write bytes it decodes from size and address
  task automatic latch_write(input logic [1:0] w);
    int a, s, b, n;
    a = int'(bus_addr[3:0]);
    s = (bus_siz == 2'b00) ? 4 : int'(bus_siz);
    case (w)
      2'b11: b = a & 3;
      2'b10: b = a & 1;
      default: b = 0;
    endcase
    n = (w == 2'b11) ? 4 - b : (w == 2'b10) ? 2 - b : 1;
    if (s < n) n = s;
    for (int j = 0; j < n; j++) mem[(a + j) & 15] = bus_dout[31-8*(b+j) -: 8];
  endtask

  task automatic run_vec(input vec_t v, input bit hold, input string tag);
    int ncyc, waits, bad;
    logic [7:0]  sizrec;
    logic [3:0]  need1;
    logic [31:0] exp;
    logic [7:0]  e;
    bit seen;
    ncyc = 0; waits = int'(v.waits); sizrec = '0; need1 = '0; seen = 0;
    mem_init();
    @(negedge clk);
    req_addr = {24'h0, v.addr}; req_len = v.len; req_write = v.wr;
    req_cache = v.cache; req_wdata = v.wdata; req_valid = 1'b1;
    @(negedge clk);
    if (hold) begin
      req_addr = 32'h9; req_len = 3'd1; req_write = ~v.wr; req_wdata = 32'hFFFFFFFF;
    end else req_valid = 1'b0;
    for (int g = 0; g < 64; g++) begin
      if (done) begin seen = 1; break; end
      if (bus_cyc) begin
        if (waits > 0) begin
          bus_ack = 2'b00;
          waits--;
        end else begin
          bus_ack = v.ack;
          if (!v.wr) drive_read(v.ack);
          #1;
          if (ncyc == 0) need1 = lane_need;
          if (ncyc < 4) sizrec[7-2*ncyc -: 2] = bus_siz;
          if (v.wr) latch_write(v.ack);
          ncyc++;
        end
      end else bus_ack = 2'b00;
      @(negedge clk);
    end
    bus_ack = 2'b00;
    req_valid = 1'b0;
    chk(seen, {tag, " R4 done seen"}, 32'(seen), 32'd1);
    chk(ncyc == int'(v.ncyc), {tag, " R3 cycle count"}, 32'(ncyc), 32'(v.ncyc));
    chk(sizrec == v.siz, {tag, " R1 size code sequence"}, 32'(sizrec), 32'(v.siz));
    if (v.waits != 0)
      chk(ncyc == int'(v.ncyc) && sizrec == v.siz, {tag, " R2 wait states hold cycle"},
          32'(ncyc), 32'(v.ncyc));
    if (v.wr || !v.cache)
      chk(need1 == v.need, {tag, " R7 lane need"}, 32'(need1), 32'(v.need));
    else
      chk(need1 == v.need, {tag, " R8 lane need"}, 32'(need1), 32'(v.need));
    if (!v.wr) begin
      exp = '0;
      for (int k = 0; k < int'(v.len); k++) exp[31-8*k -: 8] = 8'h10 + v.addr + 8'(k);
      chk(rdata == exp, {tag, " R4 R5 read result"}, rdata, exp);
    end else begin
      bad = 0;
      for (int i = 0; i < 16; i++) begin
        if (i >= int'(v.addr) && i < int'(v.addr) + int'(v.len))
          e = v.wdata[31-8*(i-int'(v.addr)) -: 8];
        else
          e = 8'h10 + 8'(i);
        if (mem[i] != e) bad++;
      end
      chk(bad == 0, {tag, " R6 memory image"}, 32'(bad), 32'd0);
    end
    @(negedge clk);
    chk(!done && req_ready, {tag, " R4 done single pulse"}, 32'(done), 32'd0);
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    mem_init();
    @(negedge clk);
    chk(req_ready && !bus_cyc && !done && lane_need == 4'b0, "R10 reset state",
        {28'h0, req_ready, bus_cyc, done, 1'b0}, 32'h8);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], 1'b0, $sformatf("vec%0d", i));

    // request inputs changing during a transfer must not disturb it
    run_vec(VEC[3], 1'b1, "R9 busy-ignore");
    run_vec(VEC[8], 1'b1, "R9 busy-ignore write");

    // asynchronous reset mid-transfer
    mem_init();
    @(negedge clk);
    req_addr = 32'h0; req_len = 3'd4; req_write = 1'b0; req_cache = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(bus_cyc && bus_siz == 2'b00 && bus_addr == 32'h0, "R1 first cycle fields",
        {bus_addr[29:0], bus_siz}, 32'h0);
    bus_ack = 2'b01; drive_read(2'b01);
    @(negedge clk);
    bus_ack = 2'b00;
    chk(bus_cyc && bus_siz == 2'b11 && bus_addr == 32'h1, "R3 after one narrow beat",
        {bus_addr[29:0], bus_siz}, {30'h1, 2'b11});
    rst_ni = 1'b0;
    #1;
    chk(!bus_cyc && req_ready && !done, "R10 async reset mid-transfer",
        {29'h0, bus_cyc, req_ready, done}, 32'h2);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    run_vec(VEC[0], 1'b0, "R10 restart");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule